// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a 32-bit register port and a fuse array that can only be programmed once. The array is modelled inside the block as a word array that clears at reset. Software first grants itself access through a mode bit. It then loads an operation code, an index and a data word, and raises a start bit. The block runs the operation and reports completion in a status word. Software must drop the start bit before it can launch the next operation.

A read fetches one row of two words into a pair of result registers. A program operation ORs a data word into one fuse word, so a bit that is already one stays one. Programming is refused until software has issued four unlock operations that carry a fixed key in a fixed order. A program operation takes longer the more one bits its data word holds. A separate operation with a fixed index and two fixed data words turns error-correction mode on or off.

Top module: `otp_ctrl`

## Requirements
- R1: After reset, every register reads zero: mode, command, start, status, index, write data and both row words. Programming is locked and the ECC flag is clear.
- R2: The register map is: mode at 0x00 (bit 0 only), command at 0x04 (bits 5:0 only), start at 0x08 (bit 0), status at 0x0C, index at 0x28 (bits 15:0 only), write data at 0x2C, even row word at 0x10, odd row word at 0x14. Bits written above a field are dropped and read back as zero.
- R3: Status bit 0 is busy, bit 1 is done, bit 2 is program-ok and bit 3 is ECC-enabled. All other status bits read zero.
- R4: An operation launches only when start goes from 0 to 1. Done stays set while start stays 1, and a second write of 1 launches nothing. Done reads 0 by the second rising edge after start is written to 0.
- R5: Read (code 0x00) with index r loads words 2r and 2r+1 into 0x10 and 0x14. Done reads 1 after the first rising edge that follows the edge taking the start write. Rows at or beyond WORDS/2 return zero.
- R6: Programming unlocks only after four unlock operations (code 0x02) whose write data are 0xF, 0x4, 0x8 and 0xD, in that order. A wrong word sends the sequence back to its first step. Lock (code 0x03) locks programming again.
- R7: Program (code 0x08) with word index a, while unlocked, makes word a equal to its old value OR the data, and sets program-ok when the read-back matches. If locked, or if a is at or beyond WORDS, the array is unchanged and program-ok stays 0.
- R8: An unlocked program sets done after PROG_BASE + PROG_PER_BIT*n + 2 rising edges, counted from the edge that takes the start write, where n is the number of one bits in the data word. This is always fewer than POLL_LIMIT cycles.
- R9: ECC control (code 0x10) at index 0x1A clears the ECC flag when the data is 0x00EC0000 and sets it when the data is 0xFF13FFFF. Any other index or data leaves the flag unchanged. Done follows after one edge.
- R10: While the mode bit is 0, every operation sets done after one edge and changes nothing: array, row words, lock state and ECC flag all keep their values, and program-ok reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset, used for both writes and reads |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |

## Verification
The assertions assume that software follows the handshake. Start is raised only from 0, and the operands are not rewritten while busy is set. Under those conditions, the operands latched at launch describe the burn that is in progress. The bench keeps to this by polling done before it touches any operand register. The one exception is the relaunch check, where the index is rewritten and start is written to 1 again, but only after done is already set.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
// Shared constants for the fuse controller: register offsets, operation
// codes, the unlock key and the engine state type. Assumes a 32-bit data bus.
package otp_pkg;
    localparam logic [7:0] OFS_MODE   = 8'h00;
    localparam logic [7:0] OFS_CMD    = 8'h04;
    localparam logic [7:0] OFS_START  = 8'h08;
    localparam logic [7:0] OFS_STAT   = 8'h0C;
    localparam logic [7:0] OFS_ROW_LO = 8'h10;
    localparam logic [7:0] OFS_ROW_HI = 8'h14;
    localparam logic [7:0] OFS_INDEX  = 8'h28;
    localparam logic [7:0] OFS_WDATA  = 8'h2C;

    localparam int CMD_W = 6;
    localparam int IDX_W = 16;

    localparam logic [CMD_W-1:0] OP_READ   = 6'h00;
    localparam logic [CMD_W-1:0] OP_UNLOCK = 6'h02;
    localparam logic [CMD_W-1:0] OP_LOCK   = 6'h03;
    localparam logic [CMD_W-1:0] OP_PROG   = 6'h08;
    localparam logic [CMD_W-1:0] OP_ECC    = 6'h10;

    localparam logic [IDX_W-1:0] ECC_CTL_IDX  = 16'h001A;
    localparam logic [31:0]      ECC_OFF_WORD = 32'h00EC0000;

    localparam int KEY_LEN = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_BURN, ST_CHECK, ST_DONE} eng_st_t;

    // Key word expected at each unlock step
    function automatic logic [31:0] key_at(input logic [2:0] step);
        case (step)
            3'd0:    key_at = 32'h0000_000F;
            3'd1:    key_at = 32'h0000_0004;
            3'd2:    key_at = 32'h0000_0008;
            default: key_at = 32'h0000_000D;
        endcase
    endfunction

    // Number of one bits in a word
    function automatic int unsigned ones32(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) n += 32'(v[i]);
        return n;
    endfunction
endpackage

// File: rtl/otp_csr.sv
`timescale 1ns/1ps
// Register file: holds the software-written operand registers and
// multiplexes the read port. Assumes writes and reads share one offset bus.
module otp_csr
    import otp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic             st_busy,
    input  logic             st_done,
    input  logic             st_ok,
    input  logic             st_ecc,
    input  logic [31:0]      row_lo,
    input  logic [31:0]      row_hi,
    output logic             mode_en,
    output logic [CMD_W-1:0] cmd_q,
    output logic [IDX_W-1:0] idx_q,
    output logic [31:0]      data_q,
    output logic             start_q,
    output logic [31:0]      bus_rdata
);
    // Capture software writes, truncated to each field's width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en <= 1'b0;
            cmd_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            start_q <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_MODE:  mode_en <= bus_wdata[0];
                OFS_CMD:   cmd_q   <= bus_wdata[CMD_W-1:0];
                OFS_START: start_q <= bus_wdata[0];
                OFS_INDEX: idx_q   <= bus_wdata[IDX_W-1:0];
                OFS_WDATA: data_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            OFS_MODE:   bus_rdata = {31'b0, mode_en};
            OFS_CMD:    bus_rdata = {{(32-CMD_W){1'b0}}, cmd_q};
            OFS_START:  bus_rdata = {31'b0, start_q};
            OFS_STAT:   bus_rdata = {28'b0, st_ecc, st_ok, st_done, st_busy};
            OFS_ROW_LO: bus_rdata = row_lo;
            OFS_ROW_HI: bus_rdata = row_hi;
            OFS_INDEX:  bus_rdata = {{(32-IDX_W){1'b0}}, idx_q};
            OFS_WDATA:  bus_rdata = data_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_unlock.sv
`timescale 1ns/1ps
// Unlock tracker: walks the fixed key one word per unlock operation. A wrong
// word restarts the walk, and a lock request clears it. Assumes key_vld pulses
// for one cycle per operation.
module otp_unlock
    import otp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_vld,
    input  logic [31:0] key_in,
    input  logic        relock,
    output logic        unlocked
);
    localparam logic [2:0] FULL = 3'(KEY_LEN);
    logic [2:0] step_q;

    assign unlocked = (step_q == FULL);

    // Advance on a matching word, restart on a mismatch
    always_ff @(posedge clk) begin
        if (!rst_n || relock)
            step_q <= '0;
        else if (key_vld && !unlocked)
            step_q <= (key_in == key_at(step_q)) ? step_q + 3'd1 : 3'd0;
    end

    a_r6_unlock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_vld));
    a_r6_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> !unlocked);
endmodule

// File: rtl/otp_fuse_array.sv
`timescale 1ns/1ps
// Fuse storage model: an array of 32-bit words that clears at reset. It has a
// row read port (two words), a single-word port and an OR-only write.
// Indices beyond the array read zero and ignore writes. Assumes WORDS is even.
module otp_fuse_array
    import otp_pkg::*;
#(
    parameter int WORDS = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] row_idx,
    input  logic [IDX_W-1:0] word_idx,
    input  logic             wr_en,
    input  logic [31:0]      wr_bits,
    output logic [31:0]      row_lo,
    output logic [31:0]      row_hi,
    output logic [31:0]      word_q,
    output logic             word_hit
);
    localparam int AW   = $clog2(WORDS);
    localparam int ROWS = WORDS / 2;

    logic [31:0] fuse [WORDS];
    logic        row_hit;
    logic [AW-1:0] w_ix;
    logic [AW-1:0] r_ix;

    assign word_hit = ({16'b0, word_idx} < 32'(WORDS));
    assign row_hit  = ({16'b0, row_idx} < 32'(ROWS));
    assign w_ix     = word_idx[AW-1:0];
    assign r_ix     = {row_idx[AW-2:0], 1'b0};

    // Clear at reset, otherwise OR new bits into the addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) fuse[i] <= '0;
        end else if (wr_en && word_hit) begin
            fuse[w_ix] <= fuse[w_ix] | wr_bits;
        end
    end

    // Row and word read ports
    always_comb begin
        row_lo = row_hit  ? fuse[r_ix]        : '0;
        row_hi = row_hit  ? fuse[r_ix | 'd1]  : '0;
        word_q = word_hit ? fuse[w_ix]        : '0;
    end
endmodule

// File: rtl/otp_engine.sv
`timescale 1ns/1ps
// Operation engine: detects the rising edge of start and runs one operation.
// A burn lasts in proportion to the data's ones count and is then verified
// by read-back. Done is held until software drops start. Assumes the operand
// registers stay put while busy.
module otp_engine
    import otp_pkg::*;
#(
    parameter int PROG_BASE    = 4,
    parameter int PROG_PER_BIT = 2,
    parameter int POLL_LIMIT   = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic [CMD_W-1:0] cmd,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      data,
    input  logic             start,
    input  logic             unlocked,
    input  logic [31:0]      row_lo_in,
    input  logic [31:0]      row_hi_in,
    input  logic [31:0]      word_in,
    input  logic             word_hit,
    output logic             key_vld,
    output logic             relock,
    output logic [IDX_W-1:0] fuse_idx,
    output logic             fuse_wr,
    output logic [31:0]      fuse_bits,
    output logic             busy,
    output logic             done,
    output logic             prog_ok,
    output logic             ecc_en,
    output logic [31:0]      row_lo_q,
    output logic [31:0]      row_hi_q
);
    localparam int MAX_LAT = PROG_BASE + PROG_PER_BIT * 32;
    localparam int CW      = $clog2(MAX_LAT + 1);

    eng_st_t          state;
    logic             start_d;
    logic [CW-1:0]    cnt;
    logic [IDX_W-1:0] op_idx;
    logic [31:0]      op_data;
    logic [31:0]      expect_q;
    logic             launch;
    logic             act;

    assign launch    = start && !start_d && (state == ST_IDLE);
    assign act       = launch && mode_en;
    assign key_vld   = act && (cmd == OP_UNLOCK);
    assign relock    = act && (cmd == OP_LOCK);
    assign fuse_idx  = op_idx;
    assign fuse_bits = op_data;
    assign fuse_wr   = (state == ST_BURN) && (cnt == CW'(1));
    assign busy      = (state == ST_BURN) || (state == ST_CHECK);
    assign done      = (state == ST_DONE);

    // Operation sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            start_d  <= 1'b0;
            cnt      <= '0;
            op_idx   <= '0;
            op_data  <= '0;
            expect_q <= '0;
            prog_ok  <= 1'b0;
            ecc_en   <= 1'b0;
            row_lo_q <= '0;
            row_hi_q <= '0;
        end else begin
            start_d <= start;
            case (state)
                ST_IDLE: if (launch) begin
                    prog_ok <= 1'b0;
                    op_idx  <= idx;
                    op_data <= data;
                    state   <= ST_DONE;
                    if (mode_en) begin
                        case (cmd)
                            OP_READ: begin
                                row_lo_q <= row_lo_in;
                                row_hi_q <= row_hi_in;
                            end
                            OP_PROG: if (unlocked) begin
                                state <= ST_BURN;
                                cnt   <= CW'(PROG_BASE + PROG_PER_BIT * ones32(data));
                            end
                            OP_ECC: if (idx == ECC_CTL_IDX) begin
                                if (data == ECC_OFF_WORD)       ecc_en <= 1'b0;
                                else if (data == ~ECC_OFF_WORD) ecc_en <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_BURN: begin
                    if (cnt == CW'(1)) begin
                        expect_q <= word_in | op_data;
                        state    <= ST_CHECK;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_CHECK: begin
                    prog_ok <= word_hit && (word_in == expect_q);
                    state   <= ST_DONE;
                end
                default: if (!start) state <= ST_IDLE;
            endcase
        end
    end

    // Busy-time counter used only by the poll-bound check
    logic [31:0] busy_cyc;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cyc <= '0;
        else                 busy_cyc <= busy_cyc + 32'd1;
    end

    a_r4_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done);
    a_r4_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_DONE || state == ST_IDLE));
    a_r7_burn_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_wr |-> unlocked);
    a_r7_or_only: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_wr |=> ((word_in & $past(word_in)) == $past(word_in)));
    a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cyc < 32'(POLL_LIMIT));
    a_r10_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !mode_en) |=> (done && !prog_ok && $stable(row_lo_q)));
    a_r9_ecc_by_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ecc_en) |-> $past(act && cmd == OP_ECC));
endmodule

// File: rtl/otp_ctrl.sv
`timescale 1ns/1ps
// Top of the fuse controller: connects the register file, the unlock tracker,
// the operation engine and the fuse storage model. Assumes one register
// access per cycle on the bus.
module otp_ctrl
    import otp_pkg::*;
#(
    parameter int WORDS        = 2048,
    parameter int PROG_BASE    = 4,
    parameter int PROG_PER_BIT = 2,
    parameter int POLL_LIMIT   = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic             mode_en, start_q, unlocked, key_vld, relock;
    logic [CMD_W-1:0] cmd_q;
    logic [IDX_W-1:0] idx_q, fuse_idx;
    logic [31:0]      data_q, fuse_bits, row_lo_a, row_hi_a, word_q;
    logic [31:0]      row_lo_q, row_hi_q;
    logic             fuse_wr, word_hit, busy, done, prog_ok, ecc_en;

    otp_csr u_csr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .st_busy(busy), .st_done(done), .st_ok(prog_ok),
        .st_ecc(ecc_en), .row_lo(row_lo_q), .row_hi(row_hi_q),
        .mode_en(mode_en), .cmd_q(cmd_q), .idx_q(idx_q), .data_q(data_q),
        .start_q(start_q), .bus_rdata(bus_rdata)
    );

    otp_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_in(data_q),
        .relock(relock), .unlocked(unlocked)
    );

    otp_engine #(
        .PROG_BASE(PROG_BASE), .PROG_PER_BIT(PROG_PER_BIT), .POLL_LIMIT(POLL_LIMIT)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .cmd(cmd_q), .idx(idx_q),
        .data(data_q), .start(start_q), .unlocked(unlocked),
        .row_lo_in(row_lo_a), .row_hi_in(row_hi_a), .word_in(word_q),
        .word_hit(word_hit), .key_vld(key_vld), .relock(relock),
        .fuse_idx(fuse_idx), .fuse_wr(fuse_wr), .fuse_bits(fuse_bits),
        .busy(busy), .done(done), .prog_ok(prog_ok), .ecc_en(ecc_en),
        .row_lo_q(row_lo_q), .row_hi_q(row_hi_q)
    );

    otp_fuse_array #(.WORDS(WORDS)) u_array (
        .clk(clk), .rst_n(rst_n), .row_idx(idx_q), .word_idx(fuse_idx),
        .wr_en(fuse_wr), .wr_bits(fuse_bits), .row_lo(row_lo_a),
        .row_hi(row_hi_a), .word_q(word_q), .word_hit(word_hit)
    );
endmodule

// File: tb/otp_ctrl_tb.sv
`timescale 1ns/1ps
module otp_ctrl_tb;
    localparam int WORDS = 16;
    localparam int PB    = 3;
    localparam int PPB   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem_m [WORDS];
    logic        unl_m = 1'b0;
    int          step_m = 0;
    logic        mode_m = 1'b0;

    always #4 clk = ~clk;

    otp_ctrl #(.WORDS(WORDS), .PROG_BASE(PB), .PROG_PER_BIT(PPB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int nones(input logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) if (v[i]) n++;
        return n;
    endfunction

    // Launch an operation and count edges until done; optionally drop start
    task automatic run(input string req, input logic [5:0] cmd, input logic [15:0] ix,
                       input logic [31:0] d, input int n_exp, input bit hold,
                       output logic [31:0] st);
        int n;
        wr(8'h04, {26'b0, cmd});
        wr(8'h28, {16'b0, ix});
        wr(8'h2C, d);
        wr(8'h08, 32'h1);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            rd(8'h0C, st);
            if (st[1] || n > 6000) break;
        end
        chk({req, " latency"}, n, n_exp);
        if (!hold) begin
            wr(8'h08, 32'h0);
            @(negedge clk);
            rd(8'h0C, st);
            chk("R4 done clears", {31'b0, st[1]}, 32'h0);
        end
    endtask

    task automatic key(input logic [31:0] d);
        logic [31:0] st;
        logic [31:0] exp_w;
        run("R6 unlock step", 6'h02, 16'h0, d, 1, 1'b0, st);
        if (mode_m && !unl_m) begin
            case (step_m)
                0: exp_w = 32'hF;
                1: exp_w = 32'h4;
                2: exp_w = 32'h8;
                default: exp_w = 32'hD;
            endcase
            if (d == exp_w) step_m++; else step_m = 0;
            if (step_m == 4) unl_m = 1'b1;
        end
    endtask

    task automatic prog(input string req, input logic [15:0] ix, input logic [31:0] d);
        logic [31:0] st;
        int   n_exp;
        logic ok;
        if (mode_m && unl_m) begin
            n_exp = PB + PPB * nones(d) + 2;
            ok = (ix < WORDS);
            if (ok) mem_m[ix] = mem_m[ix] | d;
        end else begin
            n_exp = 1;
            ok = 1'b0;
        end
        run(req, 6'h08, ix, d, n_exp, 1'b1, st);
        chk({req, " prog-ok"}, {31'b0, st[2]}, {31'b0, ok});
        chk({req, " busy low at done"}, {31'b0, st[0]}, 32'h0);
        wr(8'h08, 32'h0);
    endtask

    task automatic read_row(input string req, input logic [15:0] r);
        logic [31:0] st, lo, hi, elo, ehi;
        run(req, 6'h00, r, 32'h0, 1, 1'b0, st);
        elo = (r < WORDS/2) ? mem_m[2*r]   : 32'h0;
        ehi = (r < WORDS/2) ? mem_m[2*r+1] : 32'h0;
        rd(8'h10, lo);
        rd(8'h14, hi);
        chk({req, " even word"}, lo, elo);
        chk({req, " odd word"}, hi, ehi);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, st, lo_keep;
        for (int i = 0; i < WORDS; i++) mem_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        foreach (v[i]) ;
        rd(8'h00, v); chk("R1 mode reset", v, 0);
        rd(8'h04, v); chk("R1 command reset", v, 0);
        rd(8'h08, v); chk("R1 start reset", v, 0);
        rd(8'h0C, v); chk("R1 status reset", v, 0);
        rd(8'h28, v); chk("R1 index reset", v, 0);
        rd(8'h2C, v); chk("R1 data reset", v, 0);
        rd(8'h10, v); chk("R1 even row reset", v, 0);
        rd(8'h14, v); chk("R1 odd row reset", v, 0);

        // R2 field truncation
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 command width", v, 32'h3F);
        wr(8'h28, 32'hABCD_1234); rd(8'h28, v); chk("R2 index width", v, 32'h1234);
        wr(8'h00, 32'hFFFF_FFFE); rd(8'h00, v); chk("R2 mode bit only", v, 0);
        wr(8'h2C, 32'hDEAD_BEEF); rd(8'h2C, v); chk("R2 data register", v, 32'hDEAD_BEEF);

        // R10 operations with mode clear
        key(32'hF); key(32'h4); key(32'h8); key(32'hD);
        prog("R10 program with mode off", 16'h0, 32'hFFFF_FFFF);
        run("R10 ECC with mode off", 6'h10, 16'h1A, 32'hFF13_FFFF, 1, 1'b0, st);
        rd(8'h0C, v); chk("R10 ECC flag untouched (R3 bit 3)", {31'b0, v[3]}, 0);

        wr(8'h00, 32'h1);
        mode_m = 1'b1;
        rd(8'h00, v); chk("R2 mode set", v, 1);

        // R7 locked program; also proves mode-off key did not unlock (R10)
        prog("R7 locked program", 16'h1, 32'h0000_0001);

        // R6 wrong sequences
        key(32'hF); key(32'h4); key(32'h9); key(32'hD);
        prog("R6 wrong third word", 16'h1, 32'h0000_0001);
        key(32'hF); key(32'h4); key(32'h8); key(32'hC); key(32'hD);
        prog("R6 wrong fourth word", 16'h1, 32'h0000_0001);
        key(32'h4); key(32'hF); key(32'h8); key(32'hD);
        prog("R6 out of order", 16'h1, 32'h0000_0001);

        // R6 correct key
        key(32'hF); key(32'h4); key(32'h8); key(32'hD);

        // R7 R8 latency sweep over every ones count
        for (int k = 0; k <= 32; k++) begin
            logic [63:0] m;
            logic [31:0] d;
            int sh;
            m  = (64'h1 << k) - 64'h1;
            sh = (k * 5) % 32;
            d  = (m[31:0] << sh) | (m[31:0] >> ((32 - sh) % 32));
            if (sh == 0) d = m[31:0];
            prog("R8 ones sweep", 16'(k % WORDS), d);
        end
        prog("R7 index at WORDS", 16'(WORDS), 32'h0000_00FF);
        prog("R7 index 0xFFFF", 16'hFFFF, 32'h1);
        prog("R7 OR onto existing", 16'h3, 32'hFFFF_0000);

        // R5 read every row and beyond
        for (int r = 0; r < WORDS/2; r++) read_row("R5 row read", 16'(r));
        read_row("R5 row past end", 16'(WORDS/2));
        read_row("R5 row 0xFFFF", 16'hFFFF);

        // R10 read with mode off keeps row registers
        read_row("R5 row 2", 16'h2);
        wr(8'h00, 32'h0); mode_m = 1'b0;
        run("R10 read with mode off", 6'h00, 16'h3, 32'h0, 1, 1'b0, st);
        rd(8'h10, v); chk("R10 row kept", v, mem_m[4]);
        wr(8'h00, 32'h1); mode_m = 1'b1;

        // R4 no relaunch while start held
        run("R4 held read", 6'h00, 16'h4, 32'h0, 1, 1'b1, st);
        rd(8'h10, lo_keep); chk("R4 row 4", lo_keep, mem_m[8]);
        wr(8'h28, 32'h5);
        wr(8'h08, 32'h1);
        repeat (4) @(negedge clk);
        rd(8'h0C, v); chk("R4 done held", {31'b0, v[1]}, 1);
        rd(8'h10, v); chk("R4 no relaunch", v, mem_m[8]);
        wr(8'h08, 32'h0);
        @(negedge clk);
        rd(8'h0C, v); chk("R4 done clears", {31'b0, v[1]}, 0);
        wr(8'h08, 32'h1);
        repeat (2) @(negedge clk);
        rd(8'h10, v); chk("R4 fresh rise reads row 5", v, mem_m[10]);
        wr(8'h08, 32'h0);

        // R9 ECC control
        run("R9 enable", 6'h10, 16'h1A, 32'hFF13_FFFF, 1, 1'b0, st);
        rd(8'h0C, v); chk("R9 ECC set", {31'b0, v[3]}, 1);
        run("R9 wrong index", 6'h10, 16'h1B, 32'h00EC_0000, 1, 1'b0, st);
        rd(8'h0C, v); chk("R9 wrong index ignored", {31'b0, v[3]}, 1);
        run("R9 wrong data", 6'h10, 16'h1A, 32'h1234_5678, 1, 1'b0, st);
        rd(8'h0C, v); chk("R9 wrong data ignored", {31'b0, v[3]}, 1);
        run("R9 disable", 6'h10, 16'h1A, 32'h00EC_0000, 1, 1'b0, st);
        rd(8'h0C, v); chk("R9 ECC cleared", {31'b0, v[3]}, 0);

        // R6 lock again
        run("R6 lock", 6'h03, 16'h0, 32'h0, 1, 1'b0, st);
        unl_m = 1'b0; step_m = 0;
        prog("R6 program after lock", 16'h0, 32'h8000_0000);
        read_row("R6 array unchanged after lock", 16'h0);

        rd(8'h0C, v); chk("R3 idle status", v & 32'hFFFF_FFF0, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule